// File: doc/BRIEF.md
# Four-Phase Staggered Bias Generator

This block produces the staggered bias enables for a pipeline of self-latching gate levels. Each period of the bias waveform has four slots: evaluate, hold, reset and wait. The reference clock supplies one tick per slot, so one bias period is four reference clocks. Four bias outputs are generated. Each output runs one slot behind the output before it. As a result, a gate level evaluates during the slot in which the level feeding it is holding its result.

A pipeline deeper than four levels reuses the four outputs in turn: gate level `j` is driven by bias output `j mod 4`. The block also drives one enable and one phase code per gate level, so downstream logic can be connected level by level. At reset every output sits in the wait slot. Output 0 is the first to leave it. Each later output stays in wait until its own turn to evaluate first arrives, so no level ever starts in the middle of a hold or reset slot.

Top module: `fourph_bias_gen`

## Requirements
- R1: While `rst_n` is low, every phase code reads 11 (wait), every bias output is 0 and every level enable is 0.
- R2: Phase codes are 00 evaluate, 01 hold, 10 reset, 11 wait. Once an output has left wait for the first time, its code steps through 00, 01, 10, 11, 00, and so on, advancing by one on every clock.
- R3: After reset is released, output 0 reads evaluate after the first clock edge. Output k first reads evaluate after edge k+1 and reads wait before that.
- R4: Whenever output k reads hold, output (k+1) mod 4 reads evaluate in the same cycle.
- R5: A bias output is 1 exactly when its phase code is evaluate or hold. Adjacent outputs are therefore both high for one slot.
- R6: From the fourth cycle after reset release onward, exactly two bias outputs are high in every cycle. Before that, no more than two are high.
- R7: Level enable j and level phase code j equal bias output j mod 4 and its phase code. Level phase j occupies bits [2j+1:2j] of `lvl_phase_o`.
- R8: Asserting `rst_n` low at any time forces all outputs to the wait state immediately, without waiting for a clock edge. After release, the start-up sequence of R3 repeats exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, one tick per phase slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_o | output | 4 | Bias enables, bit k is output k |
| phase_o | output | 8 | Phase codes, output k at bits [2k+1:2k] |
| lvl_en_o | output | N_LEVELS | Per-level bias enable |
| lvl_phase_o | output | 2*N_LEVELS | Per-level phase code, level j at bits [2j+1:2j] |

## Verification
The bench builds the block with `N_LEVELS = 7`. This is more than four levels, so levels 4 to 6 must wrap back onto outputs 0 to 2, and the reuse rule of R7 is exercised beyond its trivial identity range. The four bias outputs and four phase slots are fixed by the scheme. A run of forty cycles therefore covers the full start-up ramp, many steady periods, and a restart after a mid-run reset.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    localparam int unsigned NUM_PH = 4;
    localparam int unsigned PH_W   = 2;

    typedef enum logic [1:0] {
        PH_EVAL  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_RESET = 2'd2,
        PH_WAIT  = 2'd3
    } phase_e;
endpackage

// File: rtl/fpb_ring_ctr.sv
module fpb_ring_ctr
    import fpb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] cnt_q_o,
    output logic [PH_W-1:0] cnt_nxt_o
);
    typedef struct packed {
        logic [PH_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    // The count rests on the wait slot of output 0, so that the first step lands on its evaluation.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: PH_WAIT};
        else        st_q <= st_d;
    end

    assign cnt_q_o   = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
endmodule

// File: rtl/fpb_slot.sv
module fpb_slot
    import fpb_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] cnt_nxt_i,
    output logic [PH_W-1:0] phase_o,
    output logic            bias_o
);
    localparam logic [PH_W-1:0] OFS = PH_W'(IDX % NUM_PH);

    typedef struct packed {
        logic            armed;
        logic [PH_W-1:0] phase;
        logic            bias;
    } slot_t;

    slot_t st_d, st_q;
    logic [PH_W-1:0] raw;

    always_comb begin
        st_d       = st_q;
        raw        = cnt_nxt_i - OFS;
        // The slot stays parked in wait until its own first evaluation slot arrives.
        st_d.armed = st_q.armed | (raw == PH_EVAL);
        st_d.phase = st_d.armed ? raw : PH_WAIT;
        st_d.bias  = st_d.armed & ((raw == PH_EVAL) | (raw == PH_HOLD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, phase: PH_WAIT, bias: 1'b0};
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign bias_o  = st_q.bias;
endmodule

// File: rtl/fpb_level_map.sv
module fpb_level_map
    import fpb_pkg::*;
#(
    parameter int unsigned N_LEVELS = 6
) (
    input  logic [NUM_PH-1:0]        bias_i,
    input  logic [NUM_PH*PH_W-1:0]   phase_i,
    output logic [N_LEVELS-1:0]      lvl_en_o,
    output logic [N_LEVELS*PH_W-1:0] lvl_phase_o
);
    for (genvar j = 0; j < N_LEVELS; j++) begin : g_lvl
        localparam int unsigned SRC = j % NUM_PH;
        assign lvl_en_o[j]                 = bias_i[SRC];
        assign lvl_phase_o[j*PH_W +: PH_W] = phase_i[SRC*PH_W +: PH_W];
    end
endmodule

// File: rtl/fourph_bias_gen.sv
module fourph_bias_gen
    import fpb_pkg::*;
#(
    parameter int unsigned N_LEVELS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [3:0]                bias_o,
    output logic [7:0]                phase_o,
    output logic [N_LEVELS-1:0]       lvl_en_o,
    output logic [2*N_LEVELS-1:0]     lvl_phase_o
);
    localparam int unsigned PHASE_BITS = NUM_PH * PH_W;

    logic [PH_W-1:0]       cnt_q;
    logic [PH_W-1:0]       cnt_nxt;
    logic [NUM_PH-1:0]     bias_w;
    logic [PHASE_BITS-1:0] phase_w;

    fpb_ring_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_q_o   (cnt_q),
        .cnt_nxt_o (cnt_nxt)
    );

    for (genvar k = 0; k < NUM_PH; k++) begin : g_slot
        fpb_slot #(.IDX(k)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_nxt_i (cnt_nxt),
            .phase_o   (phase_w[k*PH_W +: PH_W]),
            .bias_o    (bias_w[k])
        );
    end

    fpb_level_map #(.N_LEVELS(N_LEVELS)) u_map (
        .bias_i      (bias_w),
        .phase_i     (phase_w),
        .lvl_en_o    (lvl_en_o),
        .lvl_phase_o (lvl_phase_o)
    );

    // The count is consumed only through its next value; this keeps it visibly in use.
    logic cnt_unused;
    assign cnt_unused = ^cnt_q;

    assign bias_o  = bias_w;
    assign phase_o = phase_w;
endmodule

// File: rtl/fpb_bias_chk.sv
module fpb_bias_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bias,
    input logic [7:0] phase
);
    for (genvar k = 0; k < 4; k++) begin : g_k
        // R2
        phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (phase[2*k +: 2] != 2'd3) |=> (phase[2*k +: 2] == $past(phase[2*k +: 2]) + 2'd1));

        // R4
        stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (phase[2*k +: 2] == 2'd1) |-> (phase[2*((k+1)%4) +: 2] == 2'd0));

        // R5
        bias_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bias[k] == (phase[2*k+1] == 1'b0));
    end

    for (genvar k = 1; k < 4; k++) begin : g_rise
        // R3
        rise_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bias[k]) |-> bias[k-1]);
    end

    // R6
    max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bias) <= 2);
endmodule

bind fourph_bias_gen fpb_bias_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .bias  (bias_o),
    .phase (phase_o)
);

// File: tb/tb_fourph_bias_gen.sv
`timescale 1ns/1ps
module tb_fourph_bias_gen;
    localparam int NL = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bias_o;
    logic [7:0]    phase_o;
    logic [NL-1:0] lvl_en_o;
    logic [2*NL-1:0] lvl_phase_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    fourph_bias_gen #(.N_LEVELS(NL)) dut (
        .clk(clk), .rst_n(rst_n), .bias_o(bias_o), .phase_o(phase_o),
        .lvl_en_o(lvl_en_o), .lvl_phase_o(lvl_phase_o)
    );

    // {bias[3:0], phase[7:0]} for cycles 1..8 after reset release
    localparam logic [11:0] VEC [8] = '{
        {4'b0001, 8'hFC}, {4'b0011, 8'hF1}, {4'b0110, 8'hC6}, {4'b1100, 8'h1B},
        {4'b1001, 8'h6C}, {4'b0011, 8'hB1}, {4'b0110, 8'hC6}, {4'b1100, 8'h1B}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] exp_ph(input int t, input int k);
        if (t < k + 1) return 2'd3;
        return 2'((t - 1 - k) & 3);
    endfunction

    task automatic chk_levels(input string req);
        for (int j = 0; j < NL; j++) begin
            chk(req, {31'd0, lvl_en_o[j]}, {31'd0, bias_o[j % 4]});
            chk(req, {30'd0, lvl_phase_o[2*j +: 2]}, {30'd0, phase_o[2*(j%4) +: 2]});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 phase", {24'd0, phase_o}, 32'hFF);
        chk("R1 bias", {28'd0, bias_o}, 32'h0);
        chk("R1 lvl_en", {25'd0, lvl_en_o}, 32'h0);
        rst_n = 1'b1;
        // R2 R3 R5: start-up and first periods from the vector table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R3 phase", {24'd0, phase_o}, {24'd0, VEC[i][7:0]});
            chk("R5 bias", {28'd0, bias_o}, {28'd0, VEC[i][11:8]});
        end
        // R2 R4 R6 R7 steady run against the model
        for (int t = 9; t <= 40; t++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                chk("R2 phase", {30'd0, phase_o[2*k +: 2]}, {30'd0, exp_ph(t, k)});
                if (phase_o[2*k +: 2] == 2'd1)
                    chk("R4 next eval", {30'd0, phase_o[2*((k+1)%4) +: 2]}, 32'd0);
            end
            chk("R6 two high", $countones(bias_o), 32'd2);
            chk_levels("R7 map");
        end
        // R8 asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1;
        chk("R8 async phase", {24'd0, phase_o}, 32'hFF);
        chk("R8 async bias", {28'd0, bias_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 restart phase", {24'd0, phase_o}, {24'd0, VEC[i][7:0]});
            chk("R8 restart bias", {28'd0, bias_o}, {28'd0, VEC[i][11:8]});
            chk_levels("R7 map restart");
        end
        finish_run();
    end
endmodule